// File: doc/BRIEF.md
# Scan-Line Counter with Compare Interrupt

This block keeps track of the video line being scanned. A one-cycle `line_tick` pulse marks the start of each new line. The counter advances by one on every pulse. It wraps to zero after the last line of a frame, and the frame length depends on the selected video standard: 263 lines when `long_frame` is 0, or 312 lines when it is 1. The host writes a 9-bit target line. When a new line begins and its number equals the target, a sticky status flag is set. If that source is enabled, the `irq` output is asserted.

The host uses a small register port with four byte-wide locations. Writes take effect at the clock edge. Reads are combinational from `host_addr`. The interrupt is acknowledged by writing a 1 to the status flag. The port is plain control and status with no handshake: every write is accepted in the cycle it is presented, so there is no back-pressure.

Register map, selected by `host_addr`:
- 0, MODE: bit 7 is written as bit 8 of the target line and read back as bit 8 of the current line. Bits 6:0 are general storage.
- 1, LINE: a write sets target bits 7:0. A read returns current line bits 7:0.
- 2, FLAGS: bit 0 is the raster flag. Bit 7 is the summary bit. Bits 6:1 read as 0.
- 3, MASK: bit 0 enables the raster source onto `irq`. Bits 7:1 read as 0.

Top module: `scanline_irq`

## Requirements
- R1: After reset, the line count, the FLAGS register and the `irq` output are all 0. A `line_tick` pulse advances the count by 1 at the next edge, and the count holds when there is no pulse.
- R2: With `long_frame`=0, a pulse at line 262 returns the count to 0. With `long_frame`=1, a pulse at line 311 returns it to 0. Any count at or above the active last line also wraps to 0.
- R3: Reading LINE (address 1) returns count bits 7:0. Reading MODE (address 0) returns count bit 8 in bit 7 and the stored bits 6:0 below it.
- R4: The target line is {MODE write bit 7, LINE write bits 7:0}. Writing LINE changes only target bits 7:0, and the MODE storage bits 6:0 read back as they were last written.
- R5: FLAGS bit 0 is set in the cycle after a `line_tick` whose new count equals the target. It is never set by matching on any other cycle.
- R6: After an acknowledged match, the flag stays clear for the rest of that line. A target that is written equal to the line already in progress does not set the flag until that line next begins.
- R7: Writing FLAGS (address 2) with bit 0 = 1 clears the flag. Writing bit 0 = 0 leaves it unchanged. If a set and a clear fall in the same cycle, the set wins.
- R8: FLAGS bit 7 and `irq` are 1 exactly when the flag is set and MASK bit 0 is 1. A flag that is set while masked still reads 1 in FLAGS bit 0, and it raises `irq` as soon as it is unmasked.
- R9: FLAGS bits 6:1 and MASK bits 7:1 always read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| line_tick | input | 1 | One-cycle pulse marking the start of a new line |
| long_frame | input | 1 | 0: 263-line frame, 1: 312-line frame |
| host_wr | input | 1 | Register write strobe |
| host_addr | input | 2 | Register select |
| host_wdata | input | 8 | Write data |
| host_rdata | output | 8 | Read data for `host_addr` |
| irq | output | 1 | Interrupt request, active high |

## Verification
The compare is tested with several kinds of target:
- a low target with bit 8 clear;
- a target above 255 in the long frame, which tells bit 8 apart from a compare on the low byte only (the bench checks that line 44 does not fire for target 300);
- a target written equal to the line already in progress, which separates a compare on line start from a level compare.

Acknowledge writes with bit 0 clear and with bit 0 set, followed by idle cycles in the same line, separate write-1-to-clear from plain write and show that the flag is set once per line. Wrap tests in both frame lengths check both terminal counts.

// File: rtl/scanline_pkg.sv
package scanline_pkg;
  localparam int LINE_W = 9;
  localparam int DATA_W = 8;
  typedef enum logic [1:0] {
    REG_MODE  = 2'd0,
    REG_LINE  = 2'd1,
    REG_FLAGS = 2'd2,
    REG_MASK  = 2'd3
  } reg_sel_e;
endpackage

// File: rtl/scanline_counter.sv
module scanline_counter #(
  parameter int LINE_W  = 9,
  parameter int FRAME_S = 263,
  parameter int FRAME_L = 312
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              line_tick,
  input  logic              long_frame,
  output logic [LINE_W-1:0] line_q,
  output logic              start_q
);
  localparam logic [LINE_W-1:0] LAST_S = LINE_W'(FRAME_S - 1);
  localparam logic [LINE_W-1:0] LAST_L = LINE_W'(FRAME_L - 1);

  logic [LINE_W-1:0] last;
  assign last = long_frame ? LAST_L : LAST_S;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      line_q  <= '0;
      start_q <= 1'b0;
    end else begin
      start_q <= line_tick;
      if (line_tick) begin
        if (line_q >= last) line_q <= '0;
        else                line_q <= line_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/scanline_match.sv
module scanline_match #(
  parameter int LINE_W = 9
) (
  input  logic [LINE_W-1:0] line_q,
  input  logic [LINE_W-1:0] target,
  input  logic              start_q,
  output logic              hit
);
  // Fire only on the first cycle of a line, never as a level compare
  assign hit = start_q && (line_q == target);
endmodule

// File: rtl/scanline_regs.sv
module scanline_regs
  import scanline_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_wr,
  input  logic [1:0]        host_addr,
  input  logic [DATA_W-1:0] host_wdata,
  input  logic              hit,
  input  logic [LINE_W-1:0] line_q,
  output logic [LINE_W-1:0] target,
  output logic              flag_q,
  output logic              mask_q,
  output logic              pend,
  output logic [DATA_W-1:0] host_rdata
);
  logic [6:0] mode_low_q;
  logic       ack;

  assign ack  = host_wr && (host_addr == REG_FLAGS) && host_wdata[0];
  assign pend = flag_q && mask_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      target     <= '0;
      mode_low_q <= '0;
      mask_q     <= 1'b0;
      flag_q     <= 1'b0;
    end else begin
      if (host_wr && host_addr == REG_MODE) begin
        target[8]  <= host_wdata[7];
        mode_low_q <= host_wdata[6:0];
      end
      if (host_wr && host_addr == REG_LINE) target[7:0] <= host_wdata;
      if (host_wr && host_addr == REG_MASK) mask_q <= host_wdata[0];
      if (hit)      flag_q <= 1'b1;
      else if (ack) flag_q <= 1'b0;
    end
  end

  always_comb begin
    unique case (host_addr)
      REG_MODE:  host_rdata = {line_q[8], mode_low_q};
      REG_LINE:  host_rdata = line_q[7:0];
      REG_FLAGS: host_rdata = {pend, 6'b0, flag_q};
      default:   host_rdata = {7'b0, mask_q};
    endcase
  end
endmodule

// File: rtl/scanline_irq.sv
module scanline_irq #(
  parameter int FRAME_S = 263,
  parameter int FRAME_L = 312
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       line_tick,
  input  logic       long_frame,
  input  logic       host_wr,
  input  logic [1:0] host_addr,
  input  logic [7:0] host_wdata,
  output logic [7:0] host_rdata,
  output logic       irq
);
  import scanline_pkg::*;

  logic [LINE_W-1:0] line_q;
  logic [LINE_W-1:0] target;
  logic              start_q;
  logic              hit;
  logic              flag_q;
  logic              mask_q;
  logic              pend;

  scanline_counter #(.LINE_W(LINE_W), .FRAME_S(FRAME_S), .FRAME_L(FRAME_L)) u_cnt (
    .clk(clk), .rst_n(rst_n), .line_tick(line_tick), .long_frame(long_frame),
    .line_q(line_q), .start_q(start_q)
  );

  scanline_match #(.LINE_W(LINE_W)) u_match (
    .line_q(line_q), .target(target), .start_q(start_q), .hit(hit)
  );

  scanline_regs u_regs (
    .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_addr(host_addr),
    .host_wdata(host_wdata), .hit(hit), .line_q(line_q), .target(target),
    .flag_q(flag_q), .mask_q(mask_q), .pend(pend), .host_rdata(host_rdata)
  );

  assign irq = pend;
endmodule

// File: rtl/scanline_irq_chk.sv
module scanline_irq_chk #(
  parameter int FRAME_S = 263,
  parameter int FRAME_L = 312
) (
  input logic       clk,
  input logic       rst_n,
  input logic       line_tick,
  input logic       long_frame,
  input logic       host_wr,
  input logic [1:0] host_addr,
  input logic [7:0] host_wdata,
  input logic [8:0] line_q,
  input logic [8:0] target,
  input logic       start_q,
  input logic       flag_q,
  input logic       mask_q,
  input logic       irq
);
  logic [8:0] last;
  assign last = long_frame ? 9'(FRAME_L - 1) : 9'(FRAME_S - 1);

  // R1
  count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    line_tick && line_q < last |=> line_q == $past(line_q) + 9'd1);
  // R1
  count_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !line_tick |=> $stable(line_q));
  // R2
  frame_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    line_tick && line_q >= last |=> line_q == 9'd0);
  // R5
  flag_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag_q) |-> $past(start_q) && $past(line_q) == $past(target));
  // R7
  flag_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    host_wr && host_addr == 2'd2 && host_wdata[0] && !(start_q && line_q == target)
    |=> !flag_q);
  // R8
  irq_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq == (flag_q && mask_q));
endmodule

bind scanline_irq scanline_irq_chk #(.FRAME_S(FRAME_S), .FRAME_L(FRAME_L)) u_chk (
  .clk(clk), .rst_n(rst_n), .line_tick(line_tick), .long_frame(long_frame),
  .host_wr(host_wr), .host_addr(host_addr), .host_wdata(host_wdata),
  .line_q(line_q), .target(target), .start_q(start_q), .flag_q(flag_q),
  .mask_q(mask_q), .irq(irq)
);

// File: tb/test_scanline_irq.sv
module test_scanline_irq;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       line_tick = 1'b0;
  logic       long_frame = 1'b0;
  logic       host_wr = 1'b0;
  logic [1:0] host_addr = 2'd0;
  logic [7:0] host_wdata = 8'd0;
  logic [7:0] host_rdata;
  logic       irq;

  int n_chk = 0;
  int n_bad = 0;

  scanline_irq i_scanline_irq (
    .clk(clk), .rst_n(rst_n), .line_tick(line_tick), .long_frame(long_frame),
    .host_wr(host_wr), .host_addr(host_addr), .host_wdata(host_wdata),
    .host_rdata(host_rdata), .irq(irq)
  );

  always #5 clk = ~clk;

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; line_tick = 1'b0; host_wr = 1'b0;
    @(negedge clk);
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  // one line start followed by one idle cycle, so the flag has settled
  task automatic tick();
    line_tick = 1'b1;
    @(negedge clk);
    line_tick = 1'b0;
    @(negedge clk);
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) tick();
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    host_wr = 1'b1; host_addr = a; host_wdata = d;
    @(negedge clk);
    host_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    host_addr = a;
    #1;
    d = host_rdata;
  endtask

  task automatic t_reset();
    logic [7:0] d;
    do_reset();
    rd(2'd1, d); check("R1 reset line", d, 0);
    rd(2'd2, d); check("R1 reset flags", d, 0);
    check("R1 reset irq", irq, 0);
    rd(2'd2, d); check("R9 flags unused bits", d & 8'h7E, 0);
    @(negedge clk);
    rd(2'd1, d); check("R1 hold without tick", d, 0);
  endtask

  task automatic t_wrap_short();
    logic [7:0] d;
    do_reset(); long_frame = 1'b0;
    ticks(262);
    rd(2'd1, d); check("R3 line low at 262", d, 262 & 255);
    rd(2'd0, d); check("R3 line bit8 at 262", d[7], 1);
    tick();
    rd(2'd1, d); check("R2 short wrap", d, 0);
  endtask

  task automatic t_wrap_long();
    logic [7:0] d;
    do_reset(); long_frame = 1'b1;
    ticks(311);
    rd(2'd1, d); check("R2 long at 311", d, 311 & 255);
    tick();
    rd(2'd1, d); check("R2 long wrap", d, 0);
    long_frame = 1'b0;
  endtask

  task automatic t_low_match();
    logic [7:0] d;
    do_reset();
    wr(2'd3, 8'hFF);
    rd(2'd3, d); check("R9 mask unused bits", d, 1);
    wr(2'd1, 8'd5);
    ticks(4);
    rd(2'd2, d); check("R5 no early flag", d, 0);
    tick();
    rd(2'd2, d); check("R5 flag at line 5", d, 8'h81);
    check("R8 irq at match", irq, 1);
    wr(2'd2, 8'h00);
    rd(2'd2, d); check("R7 write0 keeps flag", d, 8'h81);
    wr(2'd2, 8'h01);
    rd(2'd2, d); check("R7 write1 clears", d, 0);
    check("R8 irq after ack", irq, 0);
    repeat (4) @(negedge clk);
    rd(2'd2, d); check("R6 once per line", d, 0);
  endtask

  task automatic t_masked();
    logic [7:0] d;
    do_reset();
    wr(2'd1, 8'd3);
    ticks(3);
    rd(2'd2, d); check("R8 masked flag", d, 8'h01);
    check("R8 masked irq", irq, 0);
    wr(2'd3, 8'h01);
    rd(2'd2, d); check("R8 unmask summary", d, 8'h81);
    check("R8 unmask irq", irq, 1);
  endtask

  task automatic t_high_match();
    logic [7:0] d;
    do_reset(); long_frame = 1'b1;
    wr(2'd0, 8'h95);
    wr(2'd1, 8'd44);
    wr(2'd3, 8'h01);
    rd(2'd0, d); check("R4 mode storage", d, 8'h15);
    ticks(44);
    rd(2'd2, d); check("R4 bit8 no fire at 44", d, 0);
    ticks(256);
    rd(2'd2, d); check("R4 fire at 300", d, 8'h81);
    rd(2'd0, d); check("R3 mode read at 300", d, 8'h95);
    rd(2'd1, d); check("R3 line read at 300", d, 44);
    long_frame = 1'b0;
  endtask

  task automatic t_same_line();
    logic [7:0] d;
    do_reset();
    ticks(10);
    wr(2'd3, 8'h01);
    wr(2'd1, 8'd10);
    repeat (3) @(negedge clk);
    rd(2'd2, d); check("R6 no fire on current line", d, 0);
    ticks(263);
    rd(2'd2, d); check("R6 fire next pass", d, 8'h81);
  endtask

  initial begin
    #1_000_000;
    n_bad++;
    $display("FAIL watchdog actual=running expected=done");
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    t_reset();
    t_wrap_short();
    t_wrap_long();
    t_low_match();
    t_masked();
    t_high_match();
    t_same_line();
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule